// File: doc/BRIEF.md
# Two-Wire Programming Port Target

This block is the device-side end of a two-wire in-circuit programming link for a small microcontroller whose instruction words are 12 bits wide. An external programmer toggles a serial clock and drives or samples a bidirectional data line. The block turns falling clock edges into 6-bit commands and, for loads and reads, into 16-clock data frames. It keeps an up-only address counter and a four-word write latch. It owns a behavioural program store made of a user array, four ID words and one configuration word.

The programmer sends a command and, where the command carries one, a data frame. An increment command steps the counter. A load places a word into the latch slot picked by the low two address bits. A begin command commits the latch to the array. An end command returns the latch to its erased state. A bulk erase wipes the store. On a read, the block takes the data pad for the data bits of the frame. Locations above the unprotected boot window read as zero when the configuration word enables protection.

The serial pins are brought into the system clock domain through two-flop synchronisers. A mode-entry input returns the port to its entry state. High-voltage detection and real cell timing are left out of scope.

Top module: `progPortTop`

## Requirements
- R1: A command is six bits, captured on falling serial-clock edges least significant bit first. Only the low four bits are decoded: 0x2 load, 0x4 read, 0x6 increment, 0x8 begin, 0xE end, 0x9 erase. Commands without a data frame take effect on the sixth falling edge. Any other low-four-bit code changes nothing.
- R2: A load frame is 16 clocks: an ignored start bit, 14 data bits least significant bit first, and an ignored stop bit. The top two data bits are discarded. The 12-bit word goes into latch slot address[1:0].
- R3: On a read, the pad output enable rises on the rising edge of the 2nd frame clock and falls on the rising edge of the 16th. Between those edges it presents 14 bits least significant bit first, and the upper two bits are 1. At reset the enable is 0.
- R4: Mode entry sets the address to 0xFFF, which selects the configuration word. The address changes only on an increment. 0xFFF increments to 0x000. After any increment, the configuration word no longer responds, and 0xFFF reads all 1s.
- R5: An increment from the last user word, 0x7FF at the default size, goes to 0x800.
- R6: Begin in user space programs all four latch words into the row given by address bits above bit 1. Programming can only clear bits: the new cell value is the old value AND the latch word.
- R7: Begin in configuration space commits only the addressed ID word (0x800–0x803), or only the configuration word while it is selected.
- R8: End returns every latch word to 0xFFF.
- R9: When configuration bit 3 is 0, user locations at 0x40 and above read as 0. Locations 0x00–0x3F, the ID words and the configuration word read normally.
- R10: Erase sets every user word and the configuration word to 0xFFF. It also erases the ID words when the address is 0x800 or above and the configuration word is not selected.
- R11: Configuration-space addresses other than the ID words and the selected configuration word read as 0xFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| modeEntry | input | 1 | Synchronous return to the program-mode entry state |
| pgmClk | input | 1 | Serial programming clock |
| pgmDatIn | input | 1 | Serial data from the programmer |
| pgmDatOut | output | 1 | Serial read data toward the pad |
| pgmDatOe | output | 1 | Pad output enable, high during read data bits |

## Verification
The read path applies two functions to the same word in the same cycle: code-protection masking and the choice between user, ID and configuration storage. The bench turns protection on, then reads an unprotected user word, a protected user word and an ID word in one pass. It expects the protected word as zero and the other two unchanged. A second overlap is erase scope against address position. The same erase command is sent once with the configuration word selected and once from ID space. The bench compares the ID word read back after each erase with the expected value.

// File: rtl/progPortPkg.sv
package progPortPkg;
  localparam int WORD_BITS = 12;

  typedef enum logic [3:0] {
    OP_LOAD  = 4'h2,
    OP_READ  = 4'h4,
    OP_INC   = 4'h6,
    OP_BEGIN = 4'h8,
    OP_ERASE = 4'h9,
    OP_END   = 4'hE
  } opCode_e;

  typedef struct packed {
    logic                 load;
    logic                 inc;
    logic                 beginPgm;
    logic                 endPgm;
    logic                 erase;
    logic [WORD_BITS-1:0] loadWord;
  } strobe_t;
endpackage

// File: rtl/progCtrl.sv
module progCtrl
  import progPortPkg::*;
#(
  parameter int CMD_W   = 6,
  parameter int FRAME_W = 14,
  parameter int WORD_W  = WORD_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              modeEntry,
  input  logic              riseEv,
  input  logic              fallEv,
  input  logic              datBit,
  input  logic [WORD_W-1:0] rdWord,
  output strobe_t           strb,
  output logic              datOut,
  output logic              datOe
);
  localparam int FRAME_LEN = FRAME_W + 2;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] FRM_LAST = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] OP_BITS  = CNT_W'(4);
  localparam logic [CNT_W-1:0] WBITS    = CNT_W'(WORD_W);

  logic               inFrame, isRead;
  logic [CNT_W-1:0]   cnt;
  logic [3:0]         opSh;
  logic [WORD_W-1:0]  frameSh;
  logic [FRAME_W-1:0] rdSh;
  logic               cmdDone;

  assign cmdDone = fallEv && !inFrame && (cnt == CMD_LAST);
  assign datOut  = rdSh[0];

  always_comb begin
    strb          = '0;
    strb.loadWord = frameSh;
    strb.load     = fallEv && inFrame && !isRead && (cnt == FRM_LAST);
    strb.inc      = cmdDone && (opSh == OP_INC);
    strb.beginPgm = cmdDone && (opSh == OP_BEGIN);
    strb.endPgm   = cmdDone && (opSh == OP_END);
    strb.erase    = cmdDone && (opSh == OP_ERASE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || modeEntry) begin
      inFrame <= 1'b0;
      isRead  <= 1'b0;
      cnt     <= '0;
      opSh    <= '0;
      frameSh <= '1;
      rdSh    <= '1;
      datOe   <= 1'b0;
    end else begin
      if (fallEv) begin
        if (!inFrame) begin
          if (cnt < OP_BITS) opSh <= {datBit, opSh[3:1]};
          if (cnt == CMD_LAST) begin
            cnt <= '0;
            if (opSh == OP_LOAD || opSh == OP_READ) begin
              inFrame <= 1'b1;
              isRead  <= (opSh == OP_READ);
              rdSh    <= {{(FRAME_W-WORD_W){1'b1}}, rdWord};
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else if (cnt == FRM_LAST) begin
          inFrame <= 1'b0;
          cnt     <= '0;
        end else begin
          cnt <= cnt + 1'b1;
          if (!isRead && cnt != '0 && cnt <= WBITS)
            frameSh <= {datBit, frameSh[WORD_W-1:1]};
        end
      end
      if (riseEv && inFrame && isRead) begin
        if (cnt == CNT_W'(1))   datOe <= 1'b1;
        else if (cnt == FRM_LAST) datOe <= 1'b0;
        else if (cnt >= CNT_W'(2)) rdSh <= {1'b1, rdSh[FRAME_W-1:1]};
      end
    end
  end
endmodule

// File: rtl/progDatapath.sv
module progDatapath
  import progPortPkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int WORD_W     = WORD_BITS,
  parameter int USER_WORDS = 2048,
  parameter int ROW_WORDS  = 4,
  parameter int ID_WORDS   = 4,
  parameter int PROT_TOP   = 64,
  parameter int CFG_BASE   = 2048,
  parameter int CP_BIT     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        modeEntry,
  input  strobe_t                     strb,
  output logic [WORD_W-1:0]           rdWord,
  output logic [ADDR_W-1:0]           addr,
  output logic                        cfgLive,
  output logic [ROW_WORDS*WORD_W-1:0] latchFlat
);
  localparam int USER_AW = $clog2(USER_WORDS);
  localparam int SLOT_W  = $clog2(ROW_WORDS);
  localparam int ID_AW   = $clog2(ID_WORDS);
  localparam logic [ADDR_W-1:0] LAST_USER = ADDR_W'(USER_WORDS - 1);
  localparam logic [ADDR_W-1:0] CFG_ADDR  = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] ID_END    = ADDR_W'(CFG_BASE + ID_WORDS);
  localparam logic [ADDR_W-1:0] PROT_ADDR = ADDR_W'(PROT_TOP);

  logic [WORD_W-1:0] mem [USER_WORDS];
  logic [WORD_W-1:0] ids [ID_WORDS];
  logic [WORD_W-1:0] cfgWord;
  logic [ROW_WORDS-1:0][WORD_W-1:0] latchQ;

  logic inUser, inId, atCfg, inCfgSpace;
  logic [SLOT_W-1:0]         slot;
  logic [USER_AW-SLOT_W-1:0] rowSel;
  logic [USER_AW-1:0]        userIdx;
  logic [ID_AW-1:0]          idIdx;

  assign inUser     = addr <= LAST_USER;
  assign inCfgSpace = addr >= CFG_ADDR;
  assign inId       = inCfgSpace && (addr < ID_END);
  assign atCfg      = (addr == '1) && cfgLive;
  assign slot       = addr[SLOT_W-1:0];
  assign rowSel     = addr[USER_AW-1:SLOT_W];
  assign userIdx    = addr[USER_AW-1:0];
  assign idIdx      = addr[ID_AW-1:0];
  assign latchFlat  = latchQ;

  always_comb begin
    if (inUser)
      rdWord = (!cfgWord[CP_BIT] && addr >= PROT_ADDR) ? '0 : mem[userIdx];
    else if (inId)  rdWord = ids[idIdx];
    else if (atCfg) rdWord = cfgWord;
    else            rdWord = '1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || modeEntry) begin
      addr    <= '1;
      cfgLive <= 1'b1;
      latchQ  <= '1;
    end else begin
      if (strb.inc) begin
        addr    <= (addr == LAST_USER) ? CFG_ADDR : addr + 1'b1;
        cfgLive <= 1'b0;
      end
      if (strb.load)        latchQ[slot] <= strb.loadWord;
      else if (strb.endPgm) latchQ <= '1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !modeEntry) begin
      if (strb.beginPgm) begin
        if (inUser) begin
          for (int i = 0; i < ROW_WORDS; i++)
            mem[{rowSel, SLOT_W'(i)}] <= mem[{rowSel, SLOT_W'(i)}] & latchQ[i];
        end else if (inId) begin
          ids[idIdx] <= ids[idIdx] & latchQ[slot];
        end else if (atCfg) begin
          cfgWord <= cfgWord & latchQ[slot];
        end
      end
      if (strb.erase) begin
        for (int i = 0; i < USER_WORDS; i++) mem[i] <= '1;
        cfgWord <= '1;
        if (inCfgSpace && !atCfg)
          for (int j = 0; j < ID_WORDS; j++) ids[j] <= '1;
      end
    end
  end
endmodule

// File: rtl/progPortTop.sv
module progPortTop
  import progPortPkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int WORD_W     = WORD_BITS,
  parameter int CMD_W      = 6,
  parameter int FRAME_W    = 14,
  parameter int USER_WORDS = 2048,
  parameter int ROW_WORDS  = 4,
  parameter int ID_WORDS   = 4,
  parameter int PROT_TOP   = 64,
  parameter int CFG_BASE   = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic modeEntry,
  input  logic pgmClk,
  input  logic pgmDatIn,
  output logic pgmDatOut,
  output logic pgmDatOe
);
  logic [1:0] clkSync, datSync;
  logic       clkPrev, riseEv, fallEv;
  strobe_t    strb;
  logic [WORD_W-1:0]           rdWord;
  logic [ADDR_W-1:0]           addr;
  logic                        cfgLive;
  logic [ROW_WORDS*WORD_W-1:0] latchFlat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clkSync <= '0;
      datSync <= '0;
      clkPrev <= 1'b0;
    end else begin
      clkSync <= {clkSync[0], pgmClk};
      datSync <= {datSync[0], pgmDatIn};
      clkPrev <= clkSync[1];
    end
  end

  assign riseEv = clkSync[1] && !clkPrev;
  assign fallEv = !clkSync[1] && clkPrev;

  progCtrl #(.CMD_W(CMD_W), .FRAME_W(FRAME_W), .WORD_W(WORD_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .modeEntry(modeEntry), .riseEv(riseEv),
    .fallEv(fallEv), .datBit(datSync[1]), .rdWord(rdWord), .strb(strb),
    .datOut(pgmDatOut), .datOe(pgmDatOe)
  );

  progDatapath #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .USER_WORDS(USER_WORDS),
    .ROW_WORDS(ROW_WORDS), .ID_WORDS(ID_WORDS), .PROT_TOP(PROT_TOP),
    .CFG_BASE(CFG_BASE)
  ) uData (
    .clk(clk), .rst_n(rst_n), .modeEntry(modeEntry), .strb(strb),
    .rdWord(rdWord), .addr(addr), .cfgLive(cfgLive), .latchFlat(latchFlat)
  );
endmodule

// File: rtl/progPortChk.sv
module progPortChk
  import progPortPkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int WORD_W     = WORD_BITS,
  parameter int ROW_WORDS  = 4,
  parameter int USER_WORDS = 2048,
  parameter int CFG_BASE   = 2048
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        modeEntry,
  input strobe_t                     strb,
  input logic [ADDR_W-1:0]           addr,
  input logic                        cfgLive,
  input logic [ROW_WORDS*WORD_W-1:0] latchFlat,
  input logic                        datOe,
  input logic                        riseEv
);
  localparam logic [ADDR_W-1:0] LAST_USER = ADDR_W'(USER_WORDS - 1);
  localparam logic [ADDR_W-1:0] CFG_ADDR  = ADDR_W'(CFG_BASE);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.load, strb.inc, strb.beginPgm, strb.endPgm, strb.erase})); // R1
  AST_OE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(datOe) |-> $past(riseEv)); // R3
  AST_ENTRY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    modeEntry |=> (addr == '1) && cfgLive); // R4
  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.inc && !modeEntry) |=> !cfgLive); // R4
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.inc && !modeEntry) |=> $stable(addr)); // R4
  AST_USER_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.inc && !modeEntry && addr == LAST_USER) |=> addr == CFG_ADDR); // R5
  AST_END_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.endPgm && !modeEntry) |=> (&latchFlat)); // R8
endmodule

bind progPortTop progPortChk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .ROW_WORDS(ROW_WORDS),
  .USER_WORDS(USER_WORDS), .CFG_BASE(CFG_BASE)
) uChk (
  .clk(clk), .rst_n(rst_n), .modeEntry(modeEntry), .strb(strb), .addr(addr),
  .cfgLive(cfgLive), .latchFlat(latchFlat), .datOe(pgmDatOe), .riseEv(riseEv)
);

// File: tb/sim_progPortTop.sv
module sim_progPortTop;
  localparam int CLK_PERIOD = 10;
  localparam int PH = 6;

  logic clk = 1'b0, rst_n = 1'b0, modeEntry = 1'b0;
  logic pgmClk = 1'b0, pgmDatIn = 1'b0;
  logic pgmDatOut, pgmDatOe;
  int cmpCnt = 0, failCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  progPortTop #(.USER_WORDS(128)) u0 (
    .clk(clk), .rst_n(rst_n), .modeEntry(modeEntry), .pgmClk(pgmClk),
    .pgmDatIn(pgmDatIn), .pgmDatOut(pgmDatOut), .pgmDatOe(pgmDatOe)
  );

  task automatic check(input string tag, input logic [13:0] act, input logic [13:0] exp);
    cmpCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic b);
    pgmDatIn = b;
    repeat (PH) @(negedge clk);
    pgmClk = 1'b1;
    repeat (PH) @(negedge clk);
    pgmClk = 1'b0;
    repeat (PH) @(negedge clk);
  endtask

  task automatic sendCmd(input logic [5:0] c);
    for (int i = 0; i < 6; i++) pulse(c[i]);
  endtask

  task automatic loadData(input logic [13:0] d);
    sendCmd(6'h02);
    pulse(1'b1);
    for (int i = 0; i < 14; i++) pulse(d[i]);
    pulse(1'b1);
  endtask

  task automatic incN(input int n);
    for (int i = 0; i < n; i++) sendCmd((i % 2) ? 6'h36 : 6'h06);
  endtask

  task automatic program1();
    sendCmd(6'h08);
    sendCmd(6'h0E);
  endtask

  task automatic readCheck(input string tag, input logic [11:0] exp);
    logic [13:0] q = '0;
    int oeBad = 0;
    sendCmd(6'h04);
    for (int k = 1; k <= 16; k++) begin
      pgmDatIn = 1'b0;
      repeat (PH) @(negedge clk);
      pgmClk = 1'b1;
      repeat (PH) @(negedge clk);
      if (pgmDatOe !== (k >= 2 && k <= 15)) oeBad++;
      if (k >= 2 && k <= 15) q[k-2] = pgmDatOut;
      pgmClk = 1'b0;
      repeat (PH) @(negedge clk);
    end
    check(tag, q, {2'b11, exp});
    check("R3 output-enable window", 14'(oeBad), 14'd0);
  endtask

  task automatic enter();
    modeEntry = 1'b1;
    repeat (3) @(negedge clk);
    modeEntry = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R3 reset output enable", 14'(pgmDatOe), 14'd0);

    // entry, erase with configuration word selected
    enter();
    sendCmd(6'h09);
    readCheck("R4 R10 config word after erase", 12'hFFF);
    incN(1);
    readCheck("R4 wrap to 0x000", 12'hFFF);
    incN(127);
    readCheck("R5 last user word", 12'hFFF);
    incN(1);
    sendCmd(6'h09);
    readCheck("R5 R10 first ID after skip and erase", 12'hFFF);

    // one-word ID programming at 0x801
    incN(1);
    loadData(14'h3A5C);
    program1();
    readCheck("R2 R7 ID word programmed, top bits dropped", 12'hA5C);
    incN(1);
    readCheck("R7 neighbour ID untouched", 12'hFFF);
    incN(2);
    readCheck("R11 reserved location", 12'hFFF);

    // unused codes leave the configuration word selected
    enter();
    sendCmd(6'h0F);
    sendCmd(6'h3B);
    readCheck("R1 unused codes ignored", 12'hFFF);
    loadData(14'h0FFA);
    program1();
    readCheck("R7 config word programmed", 12'hFFA);

    // user rows
    incN(1 + 16'h3C);
    loadData(14'h0123);
    incN(3);
    program1();
    incN(2);
    loadData(14'h0456);
    incN(1);
    loadData(14'h0789);
    incN(1);
    loadData(14'h0ABC);
    program1();
    loadData(14'h00F0);
    program1();

    enter();
    readCheck("R4 config word after re-entry", 12'hFFA);
    incN(1 + 16'h3C);
    readCheck("R6 row 0x3C slot 0", 12'h123);
    incN(1);
    readCheck("R6 row 0x3C unloaded slot", 12'hFFF);
    incN(3);
    readCheck("R8 latch slot cleared by end", 12'hFFF);
    incN(1);
    readCheck("R6 row 0x40 slot 1", 12'h456);
    incN(1);
    readCheck("R6 row 0x40 slot 2", 12'h789);
    incN(1);
    readCheck("R6 programming only clears bits", 12'h0B0);

    // protection on
    enter();
    loadData(14'h0FF2);
    program1();
    readCheck("R9 config word with protect bit 0", 12'hFF2);
    incN(1 + 16'h3F);
    readCheck("R9 boot window readable", 12'hFFF);
    incN(2);
    readCheck("R9 protected word reads zero", 12'h000);
    incN(16'h3F + 1);
    readCheck("R9 ID readable under protection", 12'hA5C);

    // erase scope
    enter();
    sendCmd(6'h09);
    readCheck("R10 config word erased", 12'hFFF);
    incN(1 + 16'h43);
    readCheck("R10 user word erased", 12'hFFF);
    incN(16'h3C + 1 + 1);
    readCheck("R10 ID kept by erase at config word", 12'hA5C);
    sendCmd(6'h09);
    readCheck("R10 ID erased from ID space", 12'hFFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, failCnt);
    $finish;
  end
endmodule